// File: doc/BRIEF.md
# Sprite Rectangle Rasterizer with Framebuffer Writer

The block accepts a stream of register writes from a graphics command port. Each write carries an 8-bit register number and a 64-bit data word. From these writes it keeps a primitive type, a flat 32-bit color and a framebuffer description, which is a base pointer and a width given in 64-pixel units. While the primitive type selects a sprite, vertex writes arrive in pairs. The first write of a pair only stores a corner. The second write stores the opposite corner and queues the whole rectangle in a two-entry FIFO.

A scan engine takes rectangles from the FIFO one at a time. It walks every pixel of the rectangle, corners included, row by row and left to right, at one pixel per clock. For each pixel it emits one framebuffer write: a byte address, the 32-bit color word and four byte enables. A busy flag covers each scan. A free-running counter totals the pixels emitted. A sticky flag records any sprite that was lost because the FIFO was full.

Top module: `sprite_raster_top`

## Requirements
- R1: After reset, `busy`, `px_valid` and `overflow` are 0 and `px_count` is 0.
- R2: Register 0x01 sets the color. Bits [31:0] of its data are emitted unchanged as `px_data`, bits [63:32] are ignored, and `px_be` is 4'hF on every emitted pixel.
- R3: Register 0x05 carries a vertex in 12.4 fixed point. The integer X is bits [15:4] and the integer Y is bits [31:20]. The fractional nibbles at [3:0] and [19:16] do not affect any emitted pixel.
- R4: Corners are inclusive. A sprite with corners (xa,ya) and (xb,yb) emits exactly (|xb-xa|+1)·(|yb-ya|+1) pixels.
- R5: Register 0x4C sets the framebuffer. The base pointer is bits [8:0] and the width W (in 64-pixel units) is bits [21:16]. The pixel byte address is base·8192 + (y·W·64 + x)·4.
- R6: Pixels come out one per clock with no gap. The order is row-major, Y from minimum to maximum and X from minimum to maximum within each row, whatever the order in which the two corners were written.
- R7: Register 0x00 bits [2:0] select the primitive. Value 6 means sprite, and a write to this register restarts vertex pairing. With sprite selected, the first vertex write only latches and the second queues the rectangle. With any other value, vertex writes produce no pixels.
- R8: `busy` is 0 in the cycle after the clock edge that samples the second vertex. It is 1 from the next edge while pixels are emitted, and it drops in the cycle after the last pixel.
- R9: The queue holds 2 pending sprites. A sprite completed while the queue is full is dropped, and `overflow` becomes 1 and stays 1 until reset.
- R10: `px_count` increments by one for each cycle in which `px_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Register write strobe |
| cmd_reg | input | 8 | Register number |
| cmd_data | input | 64 | Register data |
| px_valid | output | 1 | A pixel write is presented this cycle |
| px_addr | output | 32 | Pixel byte address |
| px_data | output | 32 | Pixel color word |
| px_be | output | 4 | Pixel byte enables |
| busy | output | 1 | A sprite is being scanned |
| overflow | output | 1 | Sticky: a sprite was dropped on a full queue |
| px_count | output | 32 | Total emitted pixels |

## Verification
Several properties are checked on every cycle. The queue never exceeds its depth, is never pushed while full and is never popped while empty. The overflow flag is sticky. The pixel counter steps exactly with `px_valid`. Inside a row, the address advances by 4 per clock and the scan position stays inside the rectangle. `busy` only drops after the final corner. The properties that depend on whole scenarios can only be shown by the bench's sprites: exact address values for different bases and widths, reversed corner order, ignored fractional bits, pairing restarts, non-sprite primitive types and the dropped third queued sprite.

// File: rtl/spr_pkg.sv
package spr_pkg;

    localparam int COORD_W = 12;
    localparam int BASE_W  = 9;
    localparam int WIDTH_W = 6;
    localparam int COLOR_W = 32;

    localparam logic [7:0] REG_PRIM   = 8'h00;
    localparam logic [7:0] REG_COLOR  = 8'h01;
    localparam logic [7:0] REG_VERTEX = 8'h05;
    localparam logic [7:0] REG_FRAME  = 8'h4C;

    localparam logic [2:0] PRIM_SPRITE = 3'd6;

    typedef struct packed {
        logic [COORD_W-1:0] xa;
        logic [COORD_W-1:0] ya;
        logic [COORD_W-1:0] xb;
        logic [COORD_W-1:0] yb;
        logic [COLOR_W-1:0] color;
        logic [BASE_W-1:0]  base;
        logic [WIDTH_W-1:0] width;
    } sprite_t;

endpackage

// File: rtl/spr_cmd_decode.sv
module spr_cmd_decode
    import spr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [7:0]  cmd_reg,
    input  logic [63:0] cmd_data,
    input  logic        q_full,
    output logic        push,
    output sprite_t     push_spr,
    output logic        overflow
);

    typedef struct packed {
        logic [2:0]         prim;
        logic [COLOR_W-1:0] color;
        logic [BASE_W-1:0]  base;
        logic [WIDTH_W-1:0] width;
        logic [COORD_W-1:0] vx;
        logic [COORD_W-1:0] vy;
        logic               half;
        logic               ovf;
    } dec_t;

    dec_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        push = 1'b0;
        push_spr.xa    = st_q.vx;
        push_spr.ya    = st_q.vy;
        push_spr.xb    = cmd_data[15:4];
        push_spr.yb    = cmd_data[31:20];
        push_spr.color = st_q.color;
        push_spr.base  = st_q.base;
        push_spr.width = st_q.width;
        if (cmd_valid) begin
            case (cmd_reg)
                REG_PRIM: begin
                    st_d.prim = cmd_data[2:0];
                    st_d.half = 1'b0;
                end
                REG_COLOR: st_d.color = cmd_data[31:0];
                REG_FRAME: begin
                    st_d.base  = cmd_data[8:0];
                    st_d.width = cmd_data[21:16];
                end
                REG_VERTEX: begin
                    if (st_q.prim == PRIM_SPRITE) begin
                        if (!st_q.half) begin
                            st_d.vx   = cmd_data[15:4];
                            st_d.vy   = cmd_data[31:20];
                            st_d.half = 1'b1;
                        end else begin
                            st_d.half = 1'b0;
                            if (q_full) st_d.ovf = 1'b1;
                            else        push     = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign overflow = st_q.ovf;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf); // R9

endmodule

// File: rtl/spr_fifo.sv
module spr_fifo
    import spr_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push,
    input  sprite_t din,
    input  logic    pop,
    output sprite_t dout,
    output logic    full,
    output logic    empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        sprite_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]    wr;
        logic [PTR_W-1:0]    rd;
        logic [CNT_W-1:0]    cnt;
    } fifo_t;

    fifo_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rd];
    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty = (st_q.cnt == '0);

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH)); // R9
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R9

endmodule

// File: rtl/spr_scan.sv
module spr_scan
    import spr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BASE_SHIFT = 13,
    parameter int CNT_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_empty,
    input  sprite_t           head,
    output logic              pop,
    output logic              px_valid,
    output logic [ADDR_W-1:0] px_addr,
    output logic [31:0]       px_data,
    output logic [3:0]        px_be,
    output logic              busy,
    output logic [CNT_W-1:0]  px_count
);

    localparam int ROW_SHIFT = 6;
    localparam int BYTE_SHIFT = 2;

    typedef struct packed {
        logic               active;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        logic [COORD_W-1:0] xmin;
        logic [COORD_W-1:0] xmax;
        logic [COORD_W-1:0] ymax;
        logic [COLOR_W-1:0] color;
        logic [BASE_W-1:0]  base;
        logic [WIDTH_W-1:0] width;
        logic [CNT_W-1:0]   cnt;
    } scan_t;

    scan_t st_d, st_q;

    logic [ADDR_W-1:0] row_pix;
    logic [ADDR_W-1:0] pix_idx;

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        if (!st_q.active) begin
            if (!q_empty) begin
                pop         = 1'b1;
                st_d.active = 1'b1;
                st_d.xmin   = (head.xa < head.xb) ? head.xa : head.xb;
                st_d.xmax   = (head.xa < head.xb) ? head.xb : head.xa;
                st_d.ymax   = (head.ya < head.yb) ? head.yb : head.ya;
                st_d.x      = st_d.xmin;
                st_d.y      = (head.ya < head.yb) ? head.ya : head.yb;
                st_d.color  = head.color;
                st_d.base   = head.base;
                st_d.width  = head.width;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.x == st_q.xmax) begin
                st_d.x = st_q.xmin;
                if (st_q.y == st_q.ymax) st_d.active = 1'b0;
                else                     st_d.y = st_q.y + 1'b1;
            end else begin
                st_d.x = st_q.x + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_pix  = ADDR_W'(st_q.y) * (ADDR_W'(st_q.width) << ROW_SHIFT);
    assign pix_idx  = row_pix + ADDR_W'(st_q.x);
    assign px_addr  = (ADDR_W'(st_q.base) << BASE_SHIFT) + (pix_idx << BYTE_SHIFT);
    assign px_valid = st_q.active;
    assign busy     = st_q.active;
    assign px_data  = st_q.color;
    assign px_be    = 4'hF;
    assign px_count = st_q.cnt;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |=> px_count == $past(px_count) + 1'b1); // R10
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !px_valid |=> $stable(px_count)); // R10
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && st_q.x != st_q.xmax) |=> (px_valid && px_addr == $past(px_addr) + 4)); // R6
    AST_IN_BOX: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |-> (st_q.x >= st_q.xmin && st_q.x <= st_q.xmax && st_q.y <= st_q.ymax)); // R4
    AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(st_q.x == st_q.xmax && st_q.y == st_q.ymax)); // R8

endmodule

// File: rtl/sprite_raster_top.sv
module sprite_raster_top
    import spr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int FIFO_DEPTH = 2,
    parameter int BASE_SHIFT = 13,
    parameter int CNT_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_reg,
    input  logic [63:0]       cmd_data,
    output logic              px_valid,
    output logic [ADDR_W-1:0] px_addr,
    output logic [31:0]       px_data,
    output logic [3:0]        px_be,
    output logic              busy,
    output logic              overflow,
    output logic [CNT_W-1:0]  px_count
);

    logic    push, pop, q_full, q_empty;
    sprite_t push_spr, head;

    spr_cmd_decode i_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_reg  (cmd_reg),
        .cmd_data (cmd_data),
        .q_full   (q_full),
        .push     (push),
        .push_spr (push_spr),
        .overflow (overflow)
    );

    spr_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push),
        .din  (push_spr),
        .pop  (pop),
        .dout (head),
        .full (q_full),
        .empty(q_empty)
    );

    spr_scan #(
        .ADDR_W    (ADDR_W),
        .BASE_SHIFT(BASE_SHIFT),
        .CNT_W     (CNT_W)
    ) i_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .q_empty (q_empty),
        .head    (head),
        .pop     (pop),
        .px_valid(px_valid),
        .px_addr (px_addr),
        .px_data (px_data),
        .px_be   (px_be),
        .busy    (busy),
        .px_count(px_count)
    );

    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !q_full); // R9

endmodule

// File: tb/test_sprite_raster_top.sv
`timescale 1ns/1ps
module test_sprite_raster_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [7:0]  cmd_reg;
    logic [63:0] cmd_data;
    logic        px_valid;
    logic [31:0] px_addr;
    logic [31:0] px_data;
    logic [3:0]  px_be;
    logic        busy;
    logic        overflow;
    logic [31:0] px_count;

    always #2 clk = ~clk;

    sprite_raster_top i_sprite_raster_top (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_reg(cmd_reg),
        .cmd_data(cmd_data), .px_valid(px_valid), .px_addr(px_addr),
        .px_data(px_data), .px_be(px_be), .busy(busy), .overflow(overflow),
        .px_count(px_count)
    );

    typedef struct packed {
        logic [11:0] xa;
        logic [11:0] ya;
        logic [11:0] xb;
        logic [11:0] yb;
        logic [5:0]  w;
        logic [8:0]  base;
        logic [31:0] color;
        logic [3:0]  frac;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{12'd0, 12'd0, 12'd3, 12'd3, 6'd1, 9'd0, 32'h0000_FF30, 4'h0},
        '{12'd5, 12'd2, 12'd2, 12'd0, 6'd2, 9'd1, 32'h1234_5678, 4'h0},
        '{12'd7, 12'd9, 12'd7, 12'd9, 6'd3, 9'd0, 32'hCAFE_F00D, 4'h0},
        '{12'd0, 12'd4, 12'd9, 12'd4, 6'd1, 9'd2, 32'h00AB_CDEF, 4'hF},
        '{12'd66, 12'd1, 12'd64, 12'd2, 6'd63, 9'd511, 32'hFFFF_FFFF, 4'h9}
    };

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] r, input logic [63:0] d);
        cmd_valid = 1'b1;
        cmd_reg   = r;
        cmd_data  = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic logic [63:0] vtx(input logic [11:0] x, input logic [11:0] y,
                                        input logic [3:0] f);
        return {32'hFFFF_0000, y, f, x, f};
    endfunction

    function automatic logic [31:0] exp_addr(input int x, input int y, input int w,
                                             input int b);
        longint a;
        a = longint'(b) * 8192 + (longint'(y) * w * 64 + x) * 4;
        return a[31:0];
    endfunction

    task automatic run_vec(input vec_t v);
        int xl, xh, yl, yh;
        logic [31:0] c0;
        xl = (v.xa < v.xb) ? int'(v.xa) : int'(v.xb);
        xh = (v.xa < v.xb) ? int'(v.xb) : int'(v.xa);
        yl = (v.ya < v.yb) ? int'(v.ya) : int'(v.yb);
        yh = (v.ya < v.yb) ? int'(v.yb) : int'(v.ya);
        wr(8'h00, 64'd6);
        wr(8'h01, {32'hA5A5_5A5A, v.color});
        wr(8'h4C, {42'd0, v.w, 7'd0, v.base});
        wr(8'h05, vtx(v.xa, v.ya, v.frac));
        c0 = px_count;
        wr(8'h05, vtx(v.xb, v.yb, v.frac));
        check(busy == 1'b0, "R8 busy low before pop", busy, 0);
        for (int y = yl; y <= yh; y++) begin
            for (int x = xl; x <= xh; x++) begin
                logic [31:0] ea;
                @(negedge clk);
                ea = exp_addr(x, y, v.w, v.base);
                check(px_valid && busy, "R6/R8 pixel present", {px_valid, busy}, 2'b11);
                check(px_addr == ea, "R5/R3/R6 address", px_addr, ea);
                check(px_data == v.color && px_be == 4'hF, "R2 data/be",
                      {px_be, px_data}, {4'hF, v.color});
            end
        end
        @(negedge clk);
        check(!px_valid && !busy, "R8 busy falls after last pixel", {px_valid, busy}, 0);
        check(px_count - c0 == 32'((xh - xl + 1) * (yh - yl + 1)), "R4/R10 pixel total",
              px_count - c0, (xh - xl + 1) * (yh - yl + 1));
    endtask

    initial begin
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        cmd_reg = '0;
        cmd_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !px_valid && !overflow && px_count == 0, "R1 reset state",
              {busy, px_valid, overflow, px_count}, 0);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R7: non-sprite primitive, vertex writes produce nothing
        begin
            logic [31:0] c0;
            bit seen;
            c0 = px_count;
            seen = 1'b0;
            wr(8'h00, 64'd2);
            wr(8'h05, vtx(12'd1, 12'd1, 4'd0));
            wr(8'h05, vtx(12'd2, 12'd2, 4'd0));
            repeat (6) begin
                @(negedge clk);
                if (px_valid || busy) seen = 1'b1;
            end
            check(!seen && px_count == c0, "R7 non-sprite no pixels", px_count, c0);
        end

        // R7: primitive rewrite restarts pairing
        begin
            logic [31:0] c0;
            c0 = px_count;
            wr(8'h00, 64'd6);
            wr(8'h05, vtx(12'd20, 12'd20, 4'd0));
            wr(8'h00, 64'd6);
            wr(8'h05, vtx(12'd1, 12'd0, 4'd0));
            wr(8'h05, vtx(12'd0, 12'd0, 4'd0));
            repeat (6) @(negedge clk);
            check(px_count - c0 == 2, "R7 pairing restart", px_count - c0, 2);
        end

        // R9: fill queue while scanning; fourth sprite dropped
        begin
            logic [31:0] c0;
            c0 = px_count;
            check(!overflow, "R9 overflow clear before fill", overflow, 0);
            wr(8'h00, 64'd6);
            wr(8'h05, vtx(12'd0, 12'd0, 4'd0));
            wr(8'h05, vtx(12'd3, 12'd3, 4'd0));
            repeat (3) begin
                wr(8'h05, vtx(12'd5, 12'd5, 4'd0));
                wr(8'h05, vtx(12'd5, 12'd5, 4'd0));
            end
            check(overflow, "R9 overflow set on full queue", overflow, 1);
            repeat (40) @(negedge clk);
            check(px_count - c0 == 18, "R9 dropped sprite", px_count - c0, 18);
            check(overflow, "R9 overflow sticky", overflow, 1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule